// File: doc/BRIEF.md
# Time-Aligned Periodic Pulse Generator

This block drives a square wave whose edges are placed by comparing a free-running time-of-day nanoseconds value against a scheduled edge time. Software stages three quantities: a high-phase length, a low-phase length (or a single period that is split in half), and a first-edge time. All are in nanoseconds. Nothing staged reaches the waveform until a sync strobe arrives. Three control levels sit alongside the strobe: run, halt and clear.

After a sync with run set, the output rises the first time the nanoseconds value is equal to or beyond the start time. It then falls after the high length and rises again after the low length, and repeats. The nanoseconds value wraps at a parameterised limit, one second by default, and the edge schedule wraps with it. A halt taken by sync parks the output low. A clear acts at once and returns the generator to idle.

Top module: `pulse_gen_top`

## Requirements
- R1: The high and low lengths in use are the staged lengths rounded up to the next multiple of 16 ns (a value already a multiple of 16 is kept).
- R2: With `duty_en` low, the raw high length is `period_ns/2`, the raw low length is `period_ns` minus that raw high length, and `high_ns`/`low_ns` are ignored. Both raw lengths are then rounded as in R1.
- R3: The start time in use is the staged start rounded up to a multiple of 16, and never below 16.
- R4: Staged lengths, start and control levels have no effect on the waveform until `sync_stb` is sampled high with `ctl_clr` low.
- R5: After a sync that takes run (`ctl_en`=1, `ctl_stop`=0), the output is low. It rises at the first clock edge at which `tod_ns` is equal to or past the start time, where "past" means less than half the wrap limit beyond it.
- R6: Once running, the output alternates, falling when `tod_ns` reaches the rise time plus the high length and rising when it reaches the fall time plus the low length.
- R7: A sync with `ctl_stop`=1 (halt wins over run) drives the output low from the next cycle. The output stays low until a later sync takes run.
- R8: `ctl_clr` high drives the output low from the next cycle and leaves the generator idle. A sync strobe that arrives while clear is high is ignored.
- R9: `sync_ack` is high for exactly the one cycle that follows a taken sync strobe.
- R10: Edge times wrap modulo `NS_WRAP` together with `tod_ns`, so a start or edge just past the wrap point is hit after `tod_ns` wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_ns | input | 32 | Nanoseconds field of the time-of-day counter |
| high_ns | input | 32 | Staged high length (used when `duty_en`=1) |
| low_ns | input | 32 | Staged low length (used when `duty_en`=1) |
| period_ns | input | 32 | Staged period (used when `duty_en`=0) |
| duty_en | input | 1 | 1: separate high/low lengths, 0: split period in half |
| start_ns | input | 32 | Staged first-rise time |
| ctl_en | input | 1 | Run request, taken at sync |
| ctl_clr | input | 1 | Immediate clear to idle |
| ctl_stop | input | 1 | Halt request, taken at sync, wins over run |
| sync_stb | input | 1 | Applies the staged settings |
| sync_ack | output | 1 | One-cycle acknowledge of a taken sync |
| pulse_o | output | 1 | Generated waveform |

## Verification
A taken sync shows as `sync_ack` one cycle later. A clear, or a halt taken by sync, shows as a low output in that same following cycle. The bench drives new inputs on falling edges, so each of these results is sampled at the very next falling edge. Waveform edges are registered from the `tod_ns` value present at the rising edge. A monitor stamps each output transition with the `tod_ns` value that was visible at the rising edge before the falling edge where the change is first seen. The expected rise and fall times are then exact nanosecond values computed from R1 to R3, R6 and R10. No cycle count is guessed.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int unsigned PG_NS_W = 32;
  localparam int unsigned PG_Q    = 16;

  typedef logic [PG_NS_W-1:0] pg_ns_t;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_RUN  = 2'd1,
    PG_HALT = 2'd2
  } pg_state_t;

  // Round up to the next 16 ns grid point.
  function automatic pg_ns_t pg_round16(input pg_ns_t v);
    logic [PG_NS_W:0] s;
    s = {1'b0, v} + (PG_NS_W+1)'(PG_Q - 1);
    return {s[PG_NS_W-1:4], 4'h0};
  endfunction

  // Start time: rounded, with a floor of one grid step.
  function automatic pg_ns_t pg_start_fix(input pg_ns_t v);
    pg_ns_t a;
    a = pg_round16(v);
    return (a < pg_ns_t'(PG_Q)) ? pg_ns_t'(PG_Q) : a;
  endfunction

  function automatic pg_ns_t pg_raw_high(input pg_ns_t per, input pg_ns_t hi,
                                         input logic duty);
    return duty ? hi : (per >> 1);
  endfunction

  function automatic pg_ns_t pg_raw_low(input pg_ns_t per, input pg_ns_t lo,
                                        input logic duty);
    pg_ns_t h;
    h = per >> 1;
    return duty ? lo : (per - h);
  endfunction

  // True when tod is at or within half a wrap beyond tgt.
  function automatic logic pg_reached(input pg_ns_t tod, input pg_ns_t tgt,
                                      input pg_ns_t wrap);
    logic [PG_NS_W:0] d;
    if (tod >= tgt) d = {1'b0, tod} - {1'b0, tgt};
    else            d = {1'b0, tod} + {1'b0, wrap} - {1'b0, tgt};
    return d < {2'b00, wrap[PG_NS_W-1:1]};
  endfunction

  // Add a duration modulo the wrap limit.
  function automatic pg_ns_t pg_advance(input pg_ns_t t, input pg_ns_t dur,
                                        input pg_ns_t wrap);
    logic [PG_NS_W:0] s;
    s = {1'b0, t} + {1'b0, dur};
    if (s >= {1'b0, wrap}) s = s - {1'b0, wrap};
    return s[PG_NS_W-1:0];
  endfunction

endpackage

// File: rtl/pg_shadow.sv
module pg_shadow
  import pg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  pg_ns_t high_ns,
  input  pg_ns_t low_ns,
  input  pg_ns_t period_ns,
  input  logic   duty_en,
  input  pg_ns_t start_ns,
  output pg_ns_t nx_start,
  output pg_ns_t act_hi,
  output pg_ns_t act_lo,
  output pg_ns_t act_start
);

  pg_ns_t nx_hi, nx_lo;

  always_comb begin
    nx_hi    = pg_round16(pg_raw_high(period_ns, high_ns, duty_en));
    nx_lo    = pg_round16(pg_raw_low(period_ns, low_ns, duty_en));
    nx_start = pg_start_fix(start_ns);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_hi    <= pg_ns_t'(PG_Q);
      act_lo    <= pg_ns_t'(PG_Q);
      act_start <= pg_ns_t'(PG_Q);
    end else if (take) begin
      act_hi    <= nx_hi;
      act_lo    <= nx_lo;
      act_start <= nx_start;
    end
  end

endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  logic      clr,
  input  logic      en,
  input  logic      stop,
  output pg_state_t state,
  output logic      arm,
  output logic      ack
);

  assign arm = take && en && !stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PG_IDLE;
      ack   <= 1'b0;
    end else begin
      ack <= take;
      if (clr)       state <= PG_IDLE;
      else if (take) state <= stop ? PG_HALT : (en ? PG_RUN : PG_IDLE);
    end
  end

endmodule

// File: rtl/pg_wave.sv
module pg_wave
  import pg_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1000000000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halt,
  input  logic   arm,
  input  logic   run,
  input  pg_ns_t tod_ns,
  input  pg_ns_t first_edge,
  input  pg_ns_t act_hi,
  input  pg_ns_t act_lo,
  output logic   pulse,
  output logic   edge_hit
);

  localparam pg_ns_t WRAP = pg_ns_t'(NS_WRAP);

  pg_ns_t target;

  assign edge_hit = run && pg_reached(tod_ns, target, WRAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      target <= '0;
    end else if (halt) begin
      pulse <= 1'b0;
      if (arm) target <= first_edge;
    end else if (edge_hit) begin
      pulse  <= ~pulse;
      target <= pg_advance(target, pulse ? act_lo : act_hi, WRAP);
    end
  end

endmodule

// File: rtl/pulse_gen_top.sv
module pulse_gen_top
  import pg_pkg::*;
#(
  parameter int unsigned NS_WRAP = 1000000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tod_ns,
  input  logic [31:0] high_ns,
  input  logic [31:0] low_ns,
  input  logic [31:0] period_ns,
  input  logic        duty_en,
  input  logic [31:0] start_ns,
  input  logic        ctl_en,
  input  logic        ctl_clr,
  input  logic        ctl_stop,
  input  logic        sync_stb,
  output logic        sync_ack,
  output logic        pulse_o
);

  pg_state_t state;
  pg_ns_t    nx_start, act_hi, act_lo, act_start;
  logic      take, arm, edge_hit, halt, st_run, st_halt;

  assign take    = sync_stb && !ctl_clr;
  assign halt    = ctl_clr || take;
  assign st_run  = (state == PG_RUN);
  assign st_halt = (state == PG_HALT);

  pg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .take(take),
    .high_ns(high_ns), .low_ns(low_ns), .period_ns(period_ns),
    .duty_en(duty_en), .start_ns(start_ns), .nx_start(nx_start),
    .act_hi(act_hi), .act_lo(act_lo), .act_start(act_start)
  );

  pg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .take(take), .clr(ctl_clr),
    .en(ctl_en), .stop(ctl_stop), .state(state), .arm(arm), .ack(sync_ack)
  );

  pg_wave #(.NS_WRAP(NS_WRAP)) u_wave (
    .clk(clk), .rst_n(rst_n), .halt(halt), .arm(arm), .run(st_run),
    .tod_ns(tod_ns), .first_edge(nx_start), .act_hi(act_hi),
    .act_lo(act_lo), .pulse(pulse_o), .edge_hit(edge_hit)
  );

endmodule

// File: rtl/pg_checker.sv
module pg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        sync_stb,
  input logic        sync_ack,
  input logic        pulse,
  input logic        edge_hit,
  input logic        st_halt,
  input logic [31:0] act_hi,
  input logic [31:0] act_lo,
  input logic [31:0] act_start
);

  a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_stb && !clr) |=> sync_ack);

  a_r8_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);

  a_r7_halt_low: assert property (@(posedge clk) disable iff (!rst_n)
    st_halt |-> !pulse);

  a_r1_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hi[3:0] == 4'h0) && (act_lo[3:0] == 4'h0));

  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (act_start >= 32'd16) && (act_start[3:0] == 4'h0));

  a_r6_toggle_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse != $past(pulse)) && !$past(clr) && !$past(sync_stb))
      |-> $past(edge_hit));

  a_r4_hold_settings: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_stb) |-> ($stable(act_hi) && $stable(act_lo) && $stable(act_start)));

endmodule

bind pulse_gen_top pg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clr(ctl_clr), .sync_stb(sync_stb),
  .sync_ack(sync_ack), .pulse(pulse_o), .edge_hit(edge_hit),
  .st_halt(st_halt), .act_hi(act_hi), .act_lo(act_lo), .act_start(act_start)
);

// File: tb/tb_pulse_gen_top.sv
module tb_pulse_gen_top;

  localparam int unsigned W = 1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tod = '0;
  logic [31:0] high_ns = '0, low_ns = '0, period_ns = '0, start_ns = '0;
  logic        duty_en = 1'b1, ctl_en = 1'b0, ctl_clr = 1'b0, ctl_stop = 1'b0;
  logic        sync_stb = 1'b0;
  logic        sync_ack, pulse_o;

  int checks = 0, errors = 0, cyc = 0;
  int edge_n = 0;
  logic [31:0] edge_tod [64];
  logic        edge_lvl [64];
  logic        prev = 1'b0;
  int          load_cnt = 0, load_seen = 0;
  logic [31:0] load_val = '0;

  always #5 clk = ~clk;

  pulse_gen_top #(.NS_WRAP(W)) dut (
    .clk(clk), .rst_n(rst_n), .tod_ns(tod), .high_ns(high_ns), .low_ns(low_ns),
    .period_ns(period_ns), .duty_en(duty_en), .start_ns(start_ns),
    .ctl_en(ctl_en), .ctl_clr(ctl_clr), .ctl_stop(ctl_stop),
    .sync_stb(sync_stb), .sync_ack(sync_ack), .pulse_o(pulse_o)
  );

  // Edge monitor and time-of-day model (8 ns per cycle)
  always @(negedge clk) begin
    if (pulse_o !== prev) begin
      edge_tod[edge_n & 63] = tod;
      edge_lvl[edge_n & 63] = pulse_o;
      edge_n = edge_n + 1;
      prev = pulse_o;
    end
    if (load_cnt != load_seen) begin
      tod = load_val;
      load_seen = load_cnt;
    end else begin
      tod = (tod + 32'd8 >= W) ? tod + 32'd8 - W : tod + 32'd8;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mod_add(input logic [31:0] a, input logic [31:0] b);
    longint s;
    s = longint'(a) + longint'(b);
    return (s >= W) ? 32'(s - W) : 32'(s);
  endfunction

  task automatic load_tod(input logic [31:0] v);
    @(negedge clk);
    load_val = v;
    load_cnt = load_cnt + 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_sync(input logic exp_ack, input string req);
    @(negedge clk);
    sync_stb = 1'b1;
    @(negedge clk);
    sync_stb = 1'b0;
    chk(sync_ack == exp_ack, req, sync_ack, exp_ack);
    @(negedge clk);
    chk(sync_ack == 1'b0, req, sync_ack, 0);
  endtask

  task automatic wait_edges(input int base, input int n);
    for (int i = 0; i < 20000 && edge_n < base + n; i++) @(negedge clk);
  endtask

  task automatic chk_edge(input int idx, input logic lvl, input logic [31:0] t, input string req);
    chk(edge_lvl[idx & 63] == lvl, req, edge_lvl[idx & 63], lvl);
    chk(edge_tod[idx & 63] == t, req, edge_tod[idx & 63], t);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pulse_o == 1'b0, "R7 reset output", pulse_o, 0);
    chk(sync_ack == 1'b0, "R9 reset ack", sync_ack, 0);
  endtask

  // R5 R6: first rise on start, then high 48 / low 80
  task automatic t_basic();
    int base;
    high_ns = 32'd48; low_ns = 32'd80; duty_en = 1'b1; start_ns = 32'd160;
    ctl_en = 1'b1; ctl_stop = 1'b0;
    load_tod(32'd0);
    do_sync(1'b1, "R9 ack");
    base = edge_n;
    wait_edges(base, 4);
    chk_edge(base,     1'b1, 32'd160, "R5 first rise");
    chk_edge(base + 1, 1'b0, 32'd208, "R6 fall");
    chk_edge(base + 2, 1'b1, 32'd288, "R6 rise");
    chk_edge(base + 3, 1'b0, 32'd336, "R6 fall");
  endtask

  // R4: staged change without sync leaves spacing; R1 rounding after sync
  task automatic t_stage_then_sync();
    int base;
    logic [31:0] st;
    high_ns = 32'd20; low_ns = 32'd30;
    base = edge_n;
    wait_edges(base, 4);
    for (int i = 1; i < 4; i++) begin
      logic [31:0] d;
      d = edge_tod[(base + i) & 63] - edge_tod[(base + i - 1) & 63];
      chk(d == (edge_lvl[(base + i) & 63] ? 32'd80 : 32'd48), "R4 unsynced hold", d,
          edge_lvl[(base + i) & 63] ? 80 : 48);
    end
    st = ((tod + 32'd200) >> 4) << 4;
    start_ns = st;
    do_sync(1'b1, "R9 ack");
    base = edge_n;
    wait_edges(base, 3);
    chk_edge(base,     1'b1, st,          "R4 new start");
    chk_edge(base + 1, 1'b0, st + 32'd32, "R1 high rounded");
    chk_edge(base + 2, 1'b1, st + 32'd64, "R1 low rounded");
  endtask

  // R2 R3 R10: split period, start floor, wrap
  task automatic t_split_wrap();
    int base;
    period_ns = 32'd200; duty_en = 1'b0; high_ns = 32'd999; low_ns = 32'd999;
    start_ns = 32'd5;
    load_tod(W - 400);
    do_sync(1'b1, "R9 ack");
    base = edge_n;
    wait_edges(base, 3);
    chk_edge(base,     1'b1, 32'd16,  "R3 R10 start floor after wrap");
    chk_edge(base + 1, 1'b0, 32'd128, "R2 split high");
    chk_edge(base + 2, 1'b1, 32'd240, "R2 split low");
    duty_en = 1'b1;
  endtask

  // R7: halt holds low, resumes on run sync
  task automatic t_halt();
    int base;
    logic [31:0] st;
    high_ns = 32'd48; low_ns = 32'd48;
    ctl_stop = 1'b1;
    do_sync(1'b1, "R9 ack");
    chk(pulse_o == 1'b0, "R7 halt low", pulse_o, 0);
    base = edge_n;
    repeat (80) @(negedge clk);
    chk(edge_n == base, "R7 no edges while halted", edge_n - base, 0);
    chk(pulse_o == 1'b0, "R7 still low", pulse_o, 0);
    ctl_stop = 1'b0;
    st = ((tod + 32'd200) >> 4) << 4;
    start_ns = st;
    do_sync(1'b1, "R9 ack");
    base = edge_n;
    wait_edges(base, 1);
    chk_edge(base, 1'b1, st, "R7 resume");
  endtask

  // R8: clear forces low, idle, sync ignored
  task automatic t_clear();
    int base;
    for (int i = 0; i < 500 && pulse_o != 1'b1; i++) @(negedge clk);
    chk(pulse_o == 1'b1, "R8 precondition high", pulse_o, 1);
    ctl_clr = 1'b1;
    @(negedge clk);
    chk(pulse_o == 1'b0, "R8 clear low", pulse_o, 0);
    do_sync(1'b0, "R8 sync ignored");
    base = edge_n;
    repeat (40) @(negedge clk);
    ctl_clr = 1'b0;
    repeat (60) @(negedge clk);
    chk(edge_n == base, "R8 idle after clear", edge_n - base, 0);
    chk(pulse_o == 1'b0, "R8 output low", pulse_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_stage_then_sync();
    t_split_wrap();
    t_halt();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule